// File: doc/BRIEF.md
# Grouped Error Interrupt Status Unit

This unit gathers eight device interrupt levels and twenty-three single-cycle error event pulses into one 32-bit status word. The device levels are sampled every cycle into the low byte. Each error pulse sets a sticky flag in bits 30 to 8. Bit 31 is a summary flag. It records that a new error arrived while an earlier one had not yet been cleared.

Software reaches the unit through a small synchronous register port that has three locations. The first is the status word, which is read-only. The second is an enable mask with the same bit layout as the status word. The third is a clear register, which only takes writes. Each bit of the clear register wipes a whole functional family of error flags at once, and one bit wipes the summary flag. A single registered interrupt output goes high while any enabled status bit is set.

Top module: `err_irq_status`

## Requirements
- R1: After a synchronous reset, the following are all zero: the status word, the enable mask, the read data and `irq_o`.
- R2: Status bits [7:0] equal `dev_irq_i` as sampled on the previous clock edge.
- R3: A pulse on `err_evt_i[k]` sets status bit k+8 on the next edge. The bit then stays set, whatever the input does, until its family is cleared.
- R4: A write to address 2 clears whole families, one per data bit, as follows. Bit 0 clears bits 15..10 and bit 8. Bit 1 clears bits 30 and 16. Bit 2 clears bits 21..17. Bit 3 clears bits 27 and 25..23. Bit 4 clears bits 28, 26 and 9. Bit 5 clears bits 29 and 22. Writing 0x7F clears every error flag and the summary flag.
- R5: A clear write changes no flag outside the families that are named in its data.
- R6: When an event for a flag and a clear of that flag's family occur in the same cycle, the flag ends up set.
- R7: Status bit 31 sets when an error event arrives while any flag in bits 30..8 is already set. It does not set for events that arrive while all those flags are clear. Only bit 6 of a clear write resets it, and a set in the same cycle wins over that clear.
- R8: Address 1 holds the enable mask. It is written and read back as all 32 bits.
- R9: `irq_o` is high one edge after any status bit and its enable bit are both 1, and low otherwise.
- R10: `rdata_o` is registered. One edge after `addr_i` is presented it holds the status word for address 0, the enable mask for address 1, and zero for addresses 2 and 3.
- R11: Writes to address 0 have no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq_i | input | 8 | Device interrupt levels |
| err_evt_i | input | 23 | Error event pulses; bit k maps to status bit k+8 |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 status, 1 enable, 2 clear) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A flag that is cleared by the wrong family, or one that fails to hold, shows up in the status word read back two edges after the clear write or the event. A wrongly held summary flag shows up in bit 31 of the same read. A fault in the enable path or the OR reduction shows on `irq_o` one edge after the status changes. The bench therefore reads the status word after every step, checks that families are disjoint, and checks the same-cycle set-and-clear collisions for both the flags and the summary bit.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
  localparam int STAT_W    = 32;
  localparam int ERR_LSB   = 8;
  localparam int N_GRP     = 6;
  localparam int MULTI_CLR = 6;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_ENABLE = 2'd1;
  localparam logic [1:0] A_CLEAR  = 2'd2;

  // Status bits covered by each family-clear bit (index = clear-register bit).
  localparam logic [STAT_W-1:0] GRP_MASK [N_GRP] = '{
    32'h0000_FD00,  // bus errors and bit 8
    32'h4001_0000,  // RAM parity and size fault
    32'h003E_0000,  // link errors
    32'h0B80_0000,  // request dispatch
    32'h1400_0200,  // response buffer
    32'h2040_0000   // response path
  };
endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank
  import err_irq_pkg::*;
#(
  parameter int ERR_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] evt,
  input  logic             clr_stb,
  input  logic [N_GRP-1:0] clr_grp,
  output logic [ERR_W-1:0] flags
);
  for (genvar i = 0; i < ERR_W; i++) begin : g_flag
    logic [N_GRP-1:0] hit;
    logic             clr_me;
    for (genvar g = 0; g < N_GRP; g++) begin : g_hit
      assign hit[g] = GRP_MASK[g][i+ERR_LSB];
    end
    assign clr_me = clr_stb && |(clr_grp & hit);

    always_ff @(posedge clk) begin
      if (rst)           flags[i] <= 1'b0;
      else if (evt[i])   flags[i] <= 1'b1;
      else if (clr_me)   flags[i] <= 1'b0;
    end

    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> flags[i]);
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !clr_stb) |=> flags[i]);
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
      (!flags[i] && !evt[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/err_multi_track.sv
module err_multi_track (
  input  logic clk,
  input  logic rst,
  input  logic evt_any,
  input  logic flag_any,
  input  logic clr,
  output logic multi
);
  always_ff @(posedge clk) begin
    if (rst)                        multi <= 1'b0;
    else if (evt_any && flag_any)   multi <= 1'b1;
    else if (clr)                   multi <= 1'b0;
  end

  a_r7_multi_sets: assert property (@(posedge clk) disable iff (rst)
    (evt_any && flag_any) |=> multi);
  a_r7_multi_holds: assert property (@(posedge clk) disable iff (rst)
    (multi && !clr) |=> multi);
  a_r7_no_set_when_clean: assert property (@(posedge clk) disable iff (rst)
    (!multi && !flag_any) |=> !multi);
endmodule

// File: rtl/irq_regport.sv
module irq_regport
  import err_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] status,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [STAT_W-1:0] wdata,
  output logic              clr_stb,
  output logic [STAT_W-1:0] rdata,
  output logic              irq
);
  logic [STAT_W-1:0] en_q;

  assign clr_stb = wr && (addr == A_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr && addr == A_ENABLE) en_q <= wdata;
      irq <= |(status & en_q);
      unique case (addr)
        A_STATUS: rdata <= status;
        A_ENABLE: rdata <= en_q;
        default:  rdata <= '0;
      endcase
    end
  end

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (status != '0 && (status & en_q) == '0) |=> !irq);
  a_r8_enable_written: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_ENABLE) |=> (en_q == $past(wdata)));
endmodule

// File: rtl/err_irq_status.sv
module err_irq_status
  import err_irq_pkg::*;
#(
  parameter int DEV_W = 8,
  parameter int ERR_W = 23
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DEV_W-1:0]   dev_irq_i,
  input  logic [ERR_W-1:0]   err_evt_i,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [STAT_W-1:0]  wdata_i,
  output logic [STAT_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int SW = DEV_W + ERR_W + 1;

  logic [DEV_W-1:0]  dev_q;
  logic [ERR_W-1:0]  flags;
  logic              multi;
  logic              clr_stb;
  logic [SW-1:0]     status;

  always_ff @(posedge clk) begin
    if (rst) dev_q <= '0;
    else     dev_q <= dev_irq_i;
  end

  err_flag_bank #(.ERR_W(ERR_W)) u_flags (
    .clk(clk), .rst(rst), .evt(err_evt_i), .clr_stb(clr_stb),
    .clr_grp(wdata_i[N_GRP-1:0]), .flags(flags)
  );

  err_multi_track u_multi (
    .clk(clk), .rst(rst), .evt_any(|err_evt_i), .flag_any(|flags),
    .clr(clr_stb && wdata_i[MULTI_CLR]), .multi(multi)
  );

  assign status = {multi, flags, dev_q};

  irq_regport u_port (
    .clk(clk), .rst(rst), .status(status), .wr(wr_i), .addr(addr_i),
    .wdata(wdata_i), .clr_stb(clr_stb), .rdata(rdata_o), .irq(irq_o)
  );

  a_r2_dev_mirror: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[DEV_W-1:0] == $past(dev_irq_i)));
  a_r11_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_STATUS && err_evt_i == '0) |=> ($past(flags) == flags));
endmodule

// File: tb/err_irq_status_bench.sv
module err_irq_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  dev_irq = '0;
  logic [22:0] evt = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_irq_status u_err_irq_status (
    .clk(clk), .rst(rst), .dev_irq_i(dev_irq), .err_evt_i(evt),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // Each row: event pulse (status-bit aligned), clear write, expected status.
  localparam logic [31:0] ROW_EVT [NROW] = '{
    32'h0000_0200, 32'h0001_0000, 32'h0, 32'h0, 32'h0, 32'h003E_0000,
    32'h0, 32'h0, 32'h7FFF_FF00, 32'h0, 32'h0, 32'h0 };
  localparam logic [31:0] ROW_CLR [NROW] = '{
    32'h0, 32'h0, 32'h02, 32'h40, 32'h10, 32'h0,
    32'h01, 32'h04, 32'h0, 32'h08, 32'h20, 32'h7F };
  localparam logic [31:0] ROW_EXP [NROW] = '{
    32'h0000_0200, 32'h8001_0200, 32'h8000_0200, 32'h0000_0200, 32'h0,
    32'h003E_0000, 32'h003E_0000, 32'h0, 32'h7FFF_FF00, 32'h747F_FF00,
    32'h543F_FF00, 32'h0 };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic pulse(input logic [31:0] sbits);
    @(negedge clk);
    evt = sbits[30:8];
    @(negedge clk);
    evt = '0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    check("R1 rdata", rdata, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rst = 1'b0;
    rreg(2'd0, v); check("R1 status", v, 32'h0);
    rreg(2'd1, v); check("R1 enable", v, 32'h0);

    // Table: R3 R4 R5 R7
    for (int i = 0; i < NROW; i++) begin
      if (ROW_EVT[i] != 0) pulse(ROW_EVT[i]);
      if (ROW_CLR[i] != 0) wreg(2'd2, ROW_CLR[i]);
      rreg(2'd0, v);
      check($sformatf("R3/R4/R5/R7 row %0d", i), v, ROW_EXP[i]);
    end

    // R2 device mirror and R9 interrupt masking
    @(negedge clk); dev_irq = 8'hA5;
    rreg(2'd0, v); check("R2 dev mirror", v, 32'h0000_00A5);
    check("R9 masked irq", {31'b0, irq}, 32'h0);
    wreg(2'd1, 32'h0000_0001);
    rreg(2'd1, v); check("R8 enable readback", v, 32'h0000_0001);
    check("R9 irq enabled bit", {31'b0, irq}, 32'h1);
    wreg(2'd1, 32'h0000_0002);
    rreg(2'd1, v);
    check("R9 irq disabled bit", {31'b0, irq}, 32'h0);
    @(negedge clk); dev_irq = 8'h00;
    wreg(2'd1, 32'hFFFF_FFFF);
    rreg(2'd1, v); check("R8 enable all", v, 32'hFFFF_FFFF);
    check("R9 irq none set", {31'b0, irq}, 32'h0);

    // R6 set beats clear in the same cycle
    @(negedge clk);
    evt = 23'h000100; wr = 1'b1; addr = 2'd2; wdata = 32'h02;
    @(negedge clk);
    evt = '0; wr = 1'b0; wdata = '0;
    rreg(2'd0, v); check("R6 set wins flag", v, 32'h0001_0000);
    check("R9 irq error bit", {31'b0, irq}, 32'h1);
    // R7 multi set beats multi clear
    @(negedge clk);
    evt = 23'h000100; wr = 1'b1; addr = 2'd2; wdata = 32'h42;
    @(negedge clk);
    evt = '0; wr = 1'b0; wdata = '0;
    rreg(2'd0, v); check("R7 multi set wins", v, 32'h8001_0000);

    // R11 status writes ignored
    wreg(2'd0, 32'h0000_0000);
    rreg(2'd0, v); check("R11 status write ignored", v, 32'h8001_0000);
    // R10 addresses 2 and 3 read zero
    rreg(2'd2, v); check("R10 addr2 reads zero", v, 32'h0);
    rreg(2'd3, v); check("R10 addr3 reads zero", v, 32'h0);
    // R4 full clear
    wreg(2'd2, 32'h7F);
    rreg(2'd0, v); check("R4 clear all", v, 32'h0);
    check("R9 irq drops", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule